// File: doc/BRIEF.md
# Carry-Less Multiply Engine (Low/High Half)

This block forms the carry-less product of two 64-bit operands, where partial products are combined with XOR instead of addition (polynomial multiplication over GF(2)). The full product is 127 bits wide. A per-request select returns either bits 63:0 or bits 127:64 of it.

A request is accepted through a valid/ready handshake. The second operand comes either from a per-element vector value or from a broadcast scalar value, chosen by a source flag in a small input selector. The engine is iterative. It retires one multiplier bit per clock and keeps the whole double-width product, so one pass serves both halves. The result is offered on a valid/ready output and is held there until the consumer takes it. Only 64-bit elements are handled.

Top module: `clmul_top`

## Requirements
- R1: With `wantHigh`=0 the result equals the XOR, over every set bit j (0..63) of the second operand, of the first operand shifted left by j, truncated to 64 bits.
- R2: With `wantHigh`=1 the result equals the XOR, over every set bit j (1..63) of the second operand, of the first operand shifted right by 64-j. Bit 0 of the second operand never changes the high result.
- R3: When `useScalar`=1 the second operand is `scalarB` and `vecB` has no effect. When `useScalar`=0 the second operand is `vecB` and `scalarB` has no effect.
- R4: `inReady` is 1 only while no request is in flight or waiting at the output. A request offered while `inReady`=0 is not accepted and produces no result.
- R5: `outValid` rises exactly 64 clock cycles after the rising edge that accepted the request.
- R6: While `outValid`=1 and `outReady`=0, `outValid` stays 1 and `result` stays stable. After an edge with both high, `outValid` is 0 and `inReady` is 1.
- R7: A synchronous active-high `rst` abandons any computation. In the cycle after a reset edge, `inReady`=1 and `outValid`=0.
- R8: The corner operands give the products the formulas define. A zero operand gives 0. A second operand of 1 gives the first operand as the low half and 0 as the high half. A second operand of only bit 63 gives `a<<63` as the low half and `a>>1` as the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request offered |
| inReady | output | 1 | Engine can accept a request |
| opA | input | 64 | First operand (multiplicand) |
| vecB | input | 64 | Second operand, per-element vector form |
| scalarB | input | 64 | Second operand, broadcast scalar form |
| useScalar | input | 1 | 1 selects `scalarB`, 0 selects `vecB` |
| wantHigh | input | 1 | 1 returns product bits 127:64, 0 returns bits 63:0 |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes the result |
| result | output | 64 | Selected half of the carry-less product |

## Verification
The assertions check the handshake on every cycle:
- the exact 64-cycle gap between acceptance and `outValid`;
- that `inReady` and `outValid` are never high together, and that `inReady` falls after an acceptance;
- that `result` is held while the output stalls;
- the idle state after a reset.

Only the bench's scenarios can show the arithmetic. A scoreboard compares each result against the low-shift and right-shift formulas for the corner operands and for random operands in both operand forms. The same scenarios show that the unused operand source and requests offered while busy leave the results unchanged.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture operands, clear accumulator
    logic step;   // retire one multiplier bit
  } clmulCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } clmulState_e;
endpackage

// File: rtl/clmul_opsel.sv
module clmul_opsel #(
  parameter int W = 64
) (
  input  logic         useScalar,
  input  logic [W-1:0] vecB,
  input  logic [W-1:0] scalarB,
  output logic [W-1:0] selB
);
  always_comb begin
    selB = useScalar ? scalarB : vecB;
  end
endmodule

// File: rtl/clmul_ctrl.sv
module clmul_ctrl
  import clmul_pkg::*;
#(
  parameter int STEPS = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output clmulCtrl_t strobes
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  clmulState_e state;
  logic [CW-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (inValid) begin
          state   <= ST_RUN;
          stepCnt <= '0;
        end
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST) state <= ST_DONE;
        end
        ST_DONE: if (outReady) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    inReady      = (state == ST_IDLE);
    outValid     = (state == ST_DONE);
    strobes.load = (state == ST_IDLE) && inValid;
    strobes.step = (state == ST_RUN);
  end
endmodule

// File: rtl/clmul_dpath.sv
module clmul_dpath
  import clmul_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  clmulCtrl_t   strobes,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         wantHigh,
  output logic [W-1:0] result
);
  localparam int PW = 2 * W;

  logic [PW-1:0] mcand;   // multiplicand, moves left one place per step
  logic [W-1:0]  mplier;  // multiplier, moves right one place per step
  logic [PW-1:0] acc;     // full double-width product
  logic          hiSel;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
      hiSel  <= 1'b0;
    end else if (strobes.load) begin
      mcand  <= {{W{1'b0}}, opA};
      mplier <= opB;
      acc    <= '0;
      hiSel  <= wantHigh;
    end else if (strobes.step) begin
      if (mplier[0]) acc <= acc ^ mcand;
      mcand  <= mcand << 1;
      mplier <= mplier >> 1;
    end
  end

  always_comb begin
    result = hiSel ? acc[PW-1:W] : acc[W-1:0];
  end
endmodule

// File: rtl/clmul_top.sv
module clmul_top
  import clmul_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output logic         inReady,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] vecB,
  input  logic [W-1:0] scalarB,
  input  logic         useScalar,
  input  logic         wantHigh,
  output logic         outValid,
  input  logic         outReady,
  output logic [W-1:0] result
);
  clmulCtrl_t   strobes;
  logic [W-1:0] selB;

  clmul_opsel #(.W(W)) u_opsel (
    .useScalar(useScalar), .vecB(vecB), .scalarB(scalarB), .selB(selB)
  );

  clmul_ctrl #(.STEPS(W)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strobes(strobes)
  );

  clmul_dpath #(.W(W)) u_dpath (
    .clk(clk), .rst(rst), .strobes(strobes), .opA(opA), .opB(selB),
    .wantHigh(wantHigh), .result(result)
  );
endmodule

// File: rtl/clmul_checker.sv
module clmul_checker #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         inValid,
  input logic         inReady,
  input logic         outValid,
  input logic         outReady,
  input logic [W-1:0] result
);
  localparam int LW = $clog2(W + 2) + 1;

  // edges since acceptance, plus one; zero when no request is pending
  logic [LW-1:0] sinceAccept;
  logic          prevRst = 1'b0;

  always_ff @(posedge clk) begin
    if (rst)                          sinceAccept <= '0;
    else if (inValid && inReady)      sinceAccept <= LW'(1);
    else if (outValid)                sinceAccept <= '0;
    else if (sinceAccept != '0)       sinceAccept <= sinceAccept + 1'b1;
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> (sinceAccept == LW'(W + 1)))
    else $error("R5 latency");

  assert_ready_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(inReady && outValid))
    else $error("R4 ready while result pending");

  assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> !inReady)
    else $error("R4 accepted while busy");

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(result)))
    else $error("R6 output not held");

  assert_release_R6: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady) |=> (!outValid && inReady))
    else $error("R6 output not released");

  always @(posedge clk) begin
    if (prevRst) begin
      assert_reset_idle_R7: assert (inReady && !outValid)
        else $error("R7 reset state");
    end
    prevRst <= rst;
  end
endmodule

bind clmul_top clmul_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .result(result)
);

// File: tb/sim_clmul_top.sv
`timescale 1ns/1ps
module sim_clmul_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] opA = '0, vecB = '0, scalarB = '0;
  logic        useScalar = 1'b0, wantHigh = 1'b0;
  logic        outValid;
  logic        outReady;
  logic [63:0] result;

  int checks = 0, fails = 0, cyc = 0;
  int rdyMode = 0;           // 0: always ready, 1: random stalls, 2: never ready
  logic [63:0] expQ[$];
  int          accQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;    // 200 MHz
  always @(posedge clk) cyc <= cyc + 1;

  clmul_top u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .opA(opA),
    .vecB(vecB), .scalarB(scalarB), .useScalar(useScalar), .wantHigh(wantHigh),
    .outValid(outValid), .outReady(outReady), .result(result)
  );

  // Reference: low half by left shifts, high half by right shifts
  function automatic logic [63:0] refMul(logic [63:0] a, logic [63:0] b, logic hi);
    logic [63:0] r = '0;
    if (!hi) begin
      for (int j = 0; j < 64; j++) if (b[j]) r ^= (a << j);
    end else begin
      for (int j = 1; j < 64; j++) if (b[j]) r ^= (a >> (64 - j));
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // ready driver
  initial begin
    outReady = 1'b1;
    forever begin
      @(negedge clk);
      if (rdyMode == 0) outReady = 1'b1;
      else if (rdyMode == 1) outReady = ($urandom % 3) != 0;
      else outReady = 1'b0;
    end
  end

  // driver: waits for inReady, offers one request, pushes the expected item
  task automatic send(logic [63:0] a, logic [63:0] vb, logic [63:0] sb,
                      logic us, logic hi, string tag);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    opA = a; vecB = vb; scalarB = sb; useScalar = us; wantHigh = hi;
    inValid = 1'b1;
    expQ.push_back(refMul(a, us ? sb : vb, hi));
    tagQ.push_back(tag);
    @(negedge clk);
    inValid = 1'b0;
    opA = $urandom; vecB = {$urandom, $urandom}; scalarB = {$urandom, $urandom};
    accQ.push_back(cyc);
  endtask

  task automatic drain();
    int guard = 0;
    while ((expQ.size() != 0) && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // monitor / scoreboard
  logic        seen = 1'b0, justPop = 1'b0;
  logic [63:0] held;
  always @(negedge clk) begin
    if (rst) begin
      seen = 1'b0; justPop = 1'b0;
    end else begin
      if (justPop) begin
        check("R6 release", {62'b0, outValid, inReady}, 64'h1);
        justPop = 1'b0;
      end
      if (outValid) begin
        if (expQ.size() == 0) begin
          check("R4 result without accepted request", 64'h1, 64'h0);
        end else begin
          if (!seen) begin
            check("R5 latency", 64'(cyc - accQ[0]), 64'd64);
            seen = 1'b1;
            held = result;
          end else begin
            check("R6 held result", result, held);
          end
          if (outReady) begin
            check(tagQ[0], result, expQ[0]);
            void'(expQ.pop_front()); void'(accQ.pop_front()); void'(tagQ.pop_front());
            seen = 1'b0;
            justPop = 1'b1;
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  localparam logic [63:0] ONES = '1;
  localparam logic [63:0] X1   = 64'h8d3c_51a7_f00e_2b69;
  localparam logic [63:0] X2   = 64'h1234_5678_9abc_def1;

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset state", {62'b0, outValid, inReady}, 64'h1);
    rst = 1'b0;

    // corner operands (R8, R1, R2)
    send(64'h0, X1, 64'h0, 1'b0, 1'b0, "R8 zero a low");
    send(X1, 64'h0, 64'h0, 1'b0, 1'b1, "R8 zero b high");
    send(X1, 64'h1, 64'h0, 1'b0, 1'b0, "R8 b=1 low");
    send(X1, 64'h1, 64'h0, 1'b0, 1'b1, "R2 b=1 high bit0 no effect");
    send(X1, 64'h8000_0000_0000_0000, 0, 1'b0, 1'b0, "R8 b=bit63 low");
    send(X1, 64'h8000_0000_0000_0000, 0, 1'b0, 1'b1, "R8 b=bit63 high");
    send(ONES, ONES, 64'h0, 1'b0, 1'b0, "R1 ones low");
    send(ONES, ONES, 64'h0, 1'b0, 1'b1, "R2 ones high");
    send(X2, X1 | 64'h1, 64'h0, 1'b0, 1'b1, "R2 odd b high");
    drain();
    check("R8 explicit b=1 low", refMul(X1, 64'h1, 1'b0), X1);
    check("R8 explicit bit63 high", refMul(X1, 64'h8000_0000_0000_0000, 1'b1), X1 >> 1);

    // operand source selection (R3)
    send(X2, X1, ONES, 1'b0, 1'b0, "R3 vector form low");
    send(X2, ONES, X1, 1'b1, 1'b0, "R3 scalar form low");
    send(X2, 64'h0, X1, 1'b1, 1'b1, "R3 scalar form high");
    send(X2, X1, 64'h0, 1'b0, 1'b1, "R3 vector form high");
    drain();

    // requests offered while busy are ignored (R4)
    send(X1, X2, 64'h0, 1'b0, 1'b0, "R4 busy-time request");
    for (int k = 0; k < 20; k++) begin
      opA = {$urandom, $urandom}; vecB = {$urandom, $urandom};
      wantHigh = 1'b1; inValid = 1'b1;
      @(negedge clk);
      check("R4 inReady low while busy", {63'b0, inReady}, 64'h0);
    end
    inValid = 1'b0;
    drain();
    repeat (5) @(negedge clk);

    // stalled output holds (R6)
    rdyMode = 2;
    send(ONES, X2, 64'h0, 1'b0, 1'b1, "R6 stalled result");
    repeat (75) @(negedge clk);
    check("R6 outValid held", {63'b0, outValid}, 64'h1);
    rdyMode = 0;
    drain();

    // random operands, both forms, both halves, random stalls
    rdyMode = 1;
    for (int k = 0; k < 40; k++) begin
      logic [63:0] a, b, s;
      logic us, hi;
      a = {$urandom, $urandom}; b = {$urandom, $urandom}; s = {$urandom, $urandom};
      us = k[0]; hi = k[1];
      send(a, b, s, us, hi, hi ? "R2 random high" : "R1 random low");
    end
    rdyMode = 0;
    drain();

    // reset in the middle of a computation (R7)
    send(X1, X2, 64'h0, 1'b0, 1'b0, "R7 abandoned");
    repeat (10) @(negedge clk);
    rst = 1'b1;
    expQ.delete(); accQ.delete(); tagQ.delete();
    repeat (2) @(negedge clk);
    check("R7 mid-run reset state", {62'b0, outValid, inReady}, 64'h1);
    rst = 1'b0;
    repeat (80) @(negedge clk);
    check("R7 no result after reset", {63'b0, outValid}, 64'h0);
    send(X2, ONES, 64'h0, 1'b0, 1'b1, "R7 after reset high");
    drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule